// File: doc/BRIEF.md
# Fast-Lock Timer and Test Output Controller

This block holds the digital control for a frequency synthesizer. A configuration write can start a fast-lock window. The window is counted in phase-detector cycles, at a length of 3 + 4·code, so it runs from 3 up to 63 cycles. Two fast-lock flavours exist. In the first, the window always runs to its end. In the second, a lock-detect indication ends the window early.

The block also settles which power-down state applies. The sources are the chip-enable pin and two configuration bits. It combines that state with the charge-pump three-state bit into one three-state control. Last, it selects the signal that appears on a test output pin. The choices are lock detect, the divided feedback or reference pulses, the serial data bit, or a fixed level. The pin can also be released through an output-enable.

Configuration fields are presented on input ports and are taken in on a one-cycle write strobe. The phase-detector cycle arrives as a one-cycle strobe in the block's clock domain.

Top module: `fl_mux_ctrl`

## Requirements
- R1: A write with `fl_mode_i[1]`=1 raises `fl_active_o` on the next clock edge. The flag stays high through `3 + 4*tc_code_i` PFD strobes, and it falls at the edge that samples the last of them.
- R2: A write with `fl_mode_i[1]`=0 (fast lock off) leaves `fl_active_o` low and stops a window that is already running.
- R3: With `fl_mode_i`=2'b11, lock detect high during a window clears `fl_active_o` at the next edge. With `fl_mode_i`=2'b10, lock detect has no effect on the window.
- R4: A write that turns fast lock on while a window is running restarts the count from the full timeout.
- R5: While `chip_en_i` is low, `pd_async_o` and `cp_tri_o` are high and `pd_soft_o` is low, with no clock involved.
- R6: With chip enable high, `pd_sw_i`=1 and `pd_defer_i`=0, `pd_soft_o` rises at the next edge. It falls at the first edge after `pd_sw_i` returns to 0.
- R7: With `pd_defer_i`=1, software power-down waits for the first edge that samples a PFD strobe.
- R8: An asynchronous or software power-down clears any running fast-lock window at the next edge.
- R9: `cp_tri_o` is high when `cp_hiz_i` is 1 or software power-down is active. It is low in normal operation with `cp_hiz_i`=0.
- R10: The `mux_sel_i` codes select what drives `mux_o`: 1 = lock detect, 2 = N pulse, 3 = constant 1, 4 = R pulse, 6 = serial data bit, and 5 or 7 = constant 0.
- R11: `mux_oe_o` is low only for `mux_sel_i`=0, and `mux_o` is then 0.
- R12: After reset, `fl_active_o` and `pd_soft_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfd_tick_i | input | 1 | One-cycle strobe per phase-detector cycle |
| lock_det_i | input | 1 | Digital lock detect |
| n_div_i | input | 1 | Divided feedback pulse |
| r_div_i | input | 1 | Divided reference pulse |
| sdo_i | input | 1 | Serial data output bit |
| chip_en_i | input | 1 | Chip enable pin; low forces asynchronous power-down |
| cfg_wr_i | input | 1 | Configuration write strobe |
| tc_code_i | input | TC_W | Fast-lock timeout code |
| fl_mode_i | input | 2 | Bit 1 enables fast lock; bit 0 selects the lock-terminated flavour |
| pd_sw_i | input | 1 | Software power-down request |
| pd_defer_i | input | 1 | Defer software power-down to the next PFD strobe |
| cp_hiz_i | input | 1 | Charge-pump three-state request |
| mux_sel_i | input | 3 | Test output selection |
| fl_active_o | output | 1 | Fast-lock window active |
| cp_tri_o | output | 1 | Charge-pump three-state enable |
| pd_async_o | output | 1 | Asynchronous power-down active |
| pd_soft_o | output | 1 | Software power-down active |
| mux_o | output | 1 | Test output value |
| mux_oe_o | output | 1 | Test output drive enable |

## Verification
The assertions assume two things about the inputs. The fast-lock mode and timeout fields hold steady between write strobes. The phase-detector strobe lasts one cycle. The stimulus follows both: it changes the mode and timeout fields only in the same cycle as a write, and it returns the strobe to 0 before the next edge. With those inputs, the early-clear and restart properties can compare the present mode field against the mode that the timer stored at the last write.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [2:0] {
    MX_HIZ  = 3'd0,
    MX_LOCK = 3'd1,
    MX_NDIV = 3'd2,
    MX_HIGH = 3'd3,
    MX_RDIV = 3'd4,
    MX_RSVD = 3'd5,
    MX_SDO  = 3'd6,
    MX_LOW  = 3'd7
  } mux_sel_e;

  typedef enum logic [1:0] {
    FL_OFF,
    FL_TIMED,
    FL_LOCKED
  } fl_mode_e;

  function automatic fl_mode_e decode_mode(input logic [1:0] f);
    if (!f[1])    return FL_OFF;
    else if (f[0]) return FL_LOCKED;
    else           return FL_TIMED;
  endfunction
endpackage

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int TC_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kill_i,
  input  logic            load_i,
  input  logic [1:0]      mode_i,
  input  logic [TC_W-1:0] tc_i,
  input  logic            tick_i,
  input  logic            lock_i,
  output logic            active_o
);
  import fl_pkg::*;

  fl_mode_e             mode_d;
  logic                 lock_term_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     tmo;
  logic                 act_q;

  assign mode_d = decode_mode(mode_i);
  assign tmo    = CNT_W'(3) + (CNT_W'(tc_i) << 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      cnt_q       <= '0;
      lock_term_q <= 1'b0;
    end else if (kill_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_q       <= (mode_d != FL_OFF);
      cnt_q       <= (mode_d != FL_OFF) ? tmo : '0;
      lock_term_q <= (mode_d == FL_LOCKED);
    end else if (act_q) begin
      if (lock_term_q && lock_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) act_q <= 1'b0;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_en_i,
  input  logic pd_sw_i,
  input  logic pd_defer_i,
  input  logic tick_i,
  input  logic cp_hiz_i,
  output logic pd_async_o,
  output logic pd_soft_o,
  output logic cp_tri_o
);
  logic soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     soft_q <= 1'b0;
    else if (!chip_en_i || !pd_sw_i) soft_q <= 1'b0;
    else if (!pd_defer_i || tick_i)  soft_q <= 1'b1;
  end

  // pin overrides register state without waiting for a clock
  assign pd_async_o = ~chip_en_i;
  assign pd_soft_o  = soft_q & chip_en_i;
  assign cp_tri_o   = pd_async_o | pd_soft_o | cp_hiz_i;
endmodule

// File: rtl/test_mux.sv
module test_mux (
  input  logic [2:0] sel_i,
  input  logic       lock_i,
  input  logic       n_div_i,
  input  logic       r_div_i,
  input  logic       sdo_i,
  output logic       out_o,
  output logic       oe_o
);
  import fl_pkg::*;

  always_comb begin
    oe_o  = 1'b1;
    out_o = 1'b0;
    unique case (mux_sel_e'(sel_i))
      MX_HIZ:  oe_o  = 1'b0;
      MX_LOCK: out_o = lock_i;
      MX_NDIV: out_o = n_div_i;
      MX_HIGH: out_o = 1'b1;
      MX_RDIV: out_o = r_div_i;
      MX_SDO:  out_o = sdo_i;
      MX_RSVD,
      MX_LOW:  out_o = 1'b0;
      default: out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fl_mux_ctrl.sv
module fl_mux_ctrl #(
  parameter int TC_W = 4,
  localparam int TMO_MAX = 3 + 4 * ((1 << TC_W) - 1),
  localparam int CNT_W   = $clog2(TMO_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pfd_tick_i,
  input  logic            lock_det_i,
  input  logic            n_div_i,
  input  logic            r_div_i,
  input  logic            sdo_i,
  input  logic            chip_en_i,
  input  logic            cfg_wr_i,
  input  logic [TC_W-1:0] tc_code_i,
  input  logic [1:0]      fl_mode_i,
  input  logic            pd_sw_i,
  input  logic            pd_defer_i,
  input  logic            cp_hiz_i,
  input  logic [2:0]      mux_sel_i,
  output logic            fl_active_o,
  output logic            cp_tri_o,
  output logic            pd_async_o,
  output logic            pd_soft_o,
  output logic            mux_o,
  output logic            mux_oe_o
);
  logic pd_any;

  pd_ctrl u_pd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chip_en_i  (chip_en_i),
    .pd_sw_i    (pd_sw_i),
    .pd_defer_i (pd_defer_i),
    .tick_i     (pfd_tick_i),
    .cp_hiz_i   (cp_hiz_i),
    .pd_async_o (pd_async_o),
    .pd_soft_o  (pd_soft_o),
    .cp_tri_o   (cp_tri_o)
  );

  assign pd_any = pd_async_o | pd_soft_o;

  fl_timer #(.TC_W(TC_W), .CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kill_i   (pd_any),
    .load_i   (cfg_wr_i),
    .mode_i   (fl_mode_i),
    .tc_i     (tc_code_i),
    .tick_i   (pfd_tick_i),
    .lock_i   (lock_det_i),
    .active_o (fl_active_o)
  );

  test_mux u_mux (
    .sel_i   (mux_sel_i),
    .lock_i  (lock_det_i),
    .n_div_i (n_div_i),
    .r_div_i (r_div_i),
    .sdo_i   (sdo_i),
    .out_o   (mux_o),
    .oe_o    (mux_oe_o)
  );
endmodule

// File: rtl/fl_mux_ctrl_chk.sv
module fl_mux_ctrl_chk #(
  parameter int TC_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pfd_tick_i,
  input logic            lock_det_i,
  input logic            chip_en_i,
  input logic            cfg_wr_i,
  input logic [TC_W-1:0] tc_code_i,
  input logic [1:0]      fl_mode_i,
  input logic            pd_sw_i,
  input logic            cp_hiz_i,
  input logic [2:0]      mux_sel_i,
  input logic            fl_active_o,
  input logic            cp_tri_o,
  input logic            pd_async_o,
  input logic            pd_soft_o,
  input logic            mux_o,
  input logic            mux_oe_o
);
  // R1
  fl_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_active_o) |-> $past(pfd_tick_i || lock_det_i || cfg_wr_i || pd_async_o || pd_soft_o));

  // R2
  fl_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !fl_mode_i[1] |=> !fl_active_o);

  // R3
  lock_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_active_o && fl_mode_i == 2'b11 && lock_det_i && !cfg_wr_i |=> !fl_active_o);

  // R4
  fl_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && fl_mode_i[1] && !pd_async_o && !pd_soft_o |=> fl_active_o);

  // R5
  ce_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |-> pd_async_o && cp_tri_o && !pd_soft_o);

  // R6
  soft_pd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_sw_i |=> !pd_soft_o);

  // R8
  pd_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_async_o || pd_soft_o |=> !fl_active_o);

  // R9
  cp_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_hiz_i || pd_soft_o |-> cp_tri_o);

  // R10
  mux_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_sel_i == 3'd3 |-> mux_o && mux_oe_o);

  // R11
  mux_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_oe_o |-> !mux_o && mux_sel_i == 3'd0);
endmodule

bind fl_mux_ctrl fl_mux_ctrl_chk #(.TC_W(TC_W)) u_chk (.*);

// File: tb/tb_fl_mux_ctrl.sv
module tb_fl_mux_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, lock = 0, ndiv = 0, rdiv = 0, sdo = 0, ce = 1, wr = 0;
  logic [3:0] tc = '0;
  logic [1:0] mode = '0;
  logic pd1 = 0, pd2 = 0, hiz = 0;
  logic [2:0] sel = '0;
  logic fl, cptri, pda, pds, mo, moe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fl_mux_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pfd_tick_i(tick), .lock_det_i(lock),
    .n_div_i(ndiv), .r_div_i(rdiv), .sdo_i(sdo), .chip_en_i(ce), .cfg_wr_i(wr),
    .tc_code_i(tc), .fl_mode_i(mode), .pd_sw_i(pd1), .pd_defer_i(pd2),
    .cp_hiz_i(hiz), .mux_sel_i(sel), .fl_active_o(fl), .cp_tri_o(cptri),
    .pd_async_o(pda), .pd_soft_o(pds), .mux_o(mo), .mux_oe_o(moe)
  );

  // {sel[2:0], lock, ndiv, rdiv, sdo, exp_out, exp_oe}
  localparam logic [8:0] VEC [12] = '{
    9'b000_1111_00, 9'b001_1000_11, 9'b001_0111_01, 9'b010_0100_11,
    9'b010_1011_01, 9'b011_0000_11, 9'b100_0010_11, 9'b100_1101_01,
    9'b101_1111_01, 9'b110_0001_11, 9'b110_1110_01, 9'b111_1111_01
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_fl(input logic [1:0] m, input logic [3:0] c);
    mode = m; tc = c; wr = 1;
    step();
    wr = 0;
  endtask

  task automatic tick_once();
    tick = 1;
    step();
    tick = 0;
  endtask

  // R1 window length check for one code
  task automatic run_window(input logic [3:0] c);
    int n = 3 + 4 * c;
    write_fl(2'b10, c);
    check("R1 start", fl, 1);
    for (int i = 1; i < n; i++) tick_once();
    check("R1 before end", fl, 1);
    tick_once();
    check("R1 end", fl, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #23;
    check("R12 fl reset", fl, 0);
    check("R12 pd reset", pds, 0);
    rst_n = 1;
    step();

    // R10 R11 mux table
    foreach (VEC[k]) begin
      {sel, lock, ndiv, rdiv, sdo} = VEC[k][8:2];
      #1;
      check("R10 mux_o", mo, VEC[k][1]);
      check("R11 mux_oe", moe, VEC[k][0]);
    end
    lock = 0; ndiv = 0; rdiv = 0; sdo = 0; sel = 0;
    step();

    run_window(4'd0);
    run_window(4'd2);
    run_window(4'd15);

    // R2 off write stops a window
    write_fl(2'b10, 4'd3);
    tick_once();
    write_fl(2'b01, 4'd3);
    check("R2 off stops", fl, 0);
    tick_once();
    check("R2 stays off", fl, 0);

    // R3 lock-terminated flavour
    write_fl(2'b11, 4'd5);
    tick_once();
    lock = 1;
    step();
    check("R3 lock clears", fl, 0);
    lock = 0;
    // R3 timed flavour ignores lock
    write_fl(2'b10, 4'd5);
    lock = 1;
    step(); step();
    check("R3 lock ignored", fl, 1);
    lock = 0;
    write_fl(2'b00, 4'd0);

    // R4 restart
    write_fl(2'b10, 4'd0);
    tick_once(); tick_once();
    write_fl(2'b10, 4'd0);
    tick_once(); tick_once();
    check("R4 restarted", fl, 1);
    tick_once();
    check("R4 end", fl, 0);

    // R9 normal and F3
    check("R9 normal", cptri, 0);
    hiz = 1; #1;
    check("R9 hiz", cptri, 1);
    hiz = 0; #1;

    // R6 and R8 software power-down
    write_fl(2'b10, 4'd15);
    pd1 = 1;
    step();
    check("R6 soft up", pds, 1);
    check("R9 soft tri", cptri, 1);
    step();
    check("R8 soft kill", fl, 0);
    pd1 = 0;
    step();
    check("R6 soft down", pds, 0);

    // R7 deferred
    pd1 = 1; pd2 = 1;
    step(); step();
    check("R7 waits", pds, 0);
    tick_once();
    check("R7 on tick", pds, 1);
    pd1 = 0; pd2 = 0;
    step();

    // R5 and R8 chip enable
    write_fl(2'b10, 4'd15);
    ce = 0; #1;
    check("R5 async", pda, 1);
    check("R5 tri", cptri, 1);
    pd1 = 1; #1;
    check("R5 soft masked", pds, 0);
    step();
    check("R8 async kill", fl, 0);
    ce = 1; pd1 = 0;
    step(); step();
    check("R5 release", pda, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule